// File: doc/BRIEF.md
# I/O Cycle Address Generator

This block turns one I/O operation into a bus cycle. A start strobe carries an instruction-class code together with the operands that class may use: four immediate bytes (k, l, m, n), the 8-bit accumulator and the 32-bit BC register. The block assembles the 32-bit I/O address from the operands the class selects and latches it on the address bus. It then runs either one external transaction with a single read or write strobe, or a short internal pseudo-cycle during which the bus stays quiet.

On-chip accesses reach a small register bank. The bank has three writable control bytes and a read-only version byte. Every other on-chip address, including the system-control range 8'h00 to 8'h10, reads as zero and ignores writes. The block is placed between the instruction sequencer, which supplies the class code and operands, and the external bus interface, which adds chip selects and wait states.

Top module: `io_cycle_gen`

## Requirements
- R1: Class 3'd0 (short immediate) drives address {8'h00, 8'h00, acc, n}, with the accumulator on bits 15:8 and n on bits 7:0.
- R2: Classes 3'd1 (register indirect), 3'd2 (block transfer) and the spare code 3'd7 drive all 32 address bits from bc.
- R3: Class 3'd3 drives {16'h0000, m, n}, class 3'd4 drives {8'h00, l, m, n}, and class 3'd5 drives {k, l, m, n}.
- R4: An external access (any class except 3'd6) is exactly one transaction of three cycles after the start edge. In the first cycle both strobes are high. In the second cycle rd_n is low for a read (wr=0) or wr_n is low for a write (wr=1). In the third cycle both strobes are high and done is 1. done is high for that one cycle only.
- R5: Class 3'd6 (on-chip) drives {24'h000000, n} and takes two cycles after the start edge, with done high only in the second cycle.
- R6: During an on-chip pseudo-cycle, rd_n and wr_n stay high in both cycles.
- R7: On-chip addresses 8'h17, 8'h18 and 8'h19 are writable byte registers. A write takes effect at the end of its pseudo-cycle, and a later on-chip read returns the value on rdata while done is high.
- R8: On-chip address 8'hFF reads the version value (parameter VERSION_ID, default 8'h00). Writes to it are ignored.
- R9: Any other on-chip address, including 8'h00 to 8'h10, reads 8'h00 and ignores writes.
- R10: A start that arrives while a cycle is in progress is ignored. It is neither queued nor run, and addr holds its value through done.
- R11: After reset addr is 0, rd_n and wr_n are high, done is 0 and the writable on-chip registers are 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an I/O operation (sampled when idle) |
| op_class | input | 3 | Instruction-class code |
| imm_k | input | 8 | Immediate byte for address bits 31:24 |
| imm_l | input | 8 | Immediate byte for address bits 23:16 |
| imm_m | input | 8 | Immediate byte for address bits 15:8 |
| imm_n | input | 8 | Immediate byte for address bits 7:0 |
| acc | input | 8 | Accumulator value |
| bc | input | 32 | BC register value |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write data for on-chip registers |
| addr | output | 32 | I/O address bus |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle end-of-operation pulse |
| rdata | output | 8 | On-chip read data, valid while done is high |

## Verification
Counting the start edge as edge 0, the address is due one cycle later. On the external path the strobe follows in the second cycle and done in the third. On the on-chip path done and rdata arrive in the second cycle, and a register write first shows up in the next on-chip read. The bench drives inputs on the falling edge and samples each result on the falling edge of exactly the cycle it is due. It also checks the cycle after done, to catch a pulse that lasts too long or a start that was queued. The bound checker repeats the same cycle-by-cycle schedules as clocked properties triggered by an accepted start.

// File: rtl/io_cyc_pkg.sv
package io_cyc_pkg;
  localparam int ADDR_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_SHORT  = 3'd0,
    OP_REGIND = 3'd1,
    OP_BLOCK  = 3'd2,
    OP_DIR2   = 3'd3,
    OP_DIR3   = 3'd4,
    OP_DIR4   = 3'd5,
    OP_ONCHIP = 3'd6,
    OP_SPARE  = 3'd7
  } op_class_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_STROBE  = 3'd2,
    ST_RELEASE = 3'd3,
    ST_PSEUDO1 = 3'd4,
    ST_PSEUDO2 = 3'd5
  } seq_state_e;
endpackage

// File: rtl/io_addr_form.sv
module io_addr_form
  import io_cyc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic [2:0]    op_class,
  input  logic [BW-1:0] imm_k,
  input  logic [BW-1:0] imm_l,
  input  logic [BW-1:0] imm_m,
  input  logic [BW-1:0] imm_n,
  input  logic [BW-1:0] acc,
  input  logic [AW-1:0] bc,
  output logic [AW-1:0] addr_next,
  output logic          onchip
);
  localparam int HI_W = AW - 4*BW;
  localparam logic [BW-1:0] ZB = '0;

  op_class_e cls;
  assign cls = op_class_e'(op_class);

  always_comb begin
    onchip    = 1'b0;
    addr_next = bc;
    unique case (cls)
      OP_SHORT:  addr_next = AW'({ZB, ZB, acc, imm_n});
      OP_DIR2:   addr_next = AW'({ZB, ZB, imm_m, imm_n});
      OP_DIR3:   addr_next = AW'({ZB, imm_l, imm_m, imm_n});
      OP_DIR4:   addr_next = AW'({imm_k, imm_l, imm_m, imm_n});
      OP_ONCHIP: begin
        addr_next = AW'(imm_n);
        onchip    = 1'b1;
      end
      default:   addr_next = bc;
    endcase
  end

  if (HI_W < 0) begin : g_bad_width
    initial $error("address narrower than four bytes");
  end
endmodule

// File: rtl/io_cycle_seq.sv
module io_cycle_seq
  import io_cyc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic onchip,
  output logic load,
  output logic busy,
  output logic strobe_en,
  output logic in_pseudo,
  output logic done
);
  seq_state_e state_q, state_d;

  assign busy = (state_q != ST_IDLE);
  assign load = start && !busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = onchip ? ST_PSEUDO1 : ST_SETUP;
      ST_SETUP:   state_d = ST_STROBE;
      ST_STROBE:  state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      ST_PSEUDO1: state_d = ST_PSEUDO2;
      ST_PSEUDO2: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign strobe_en = (state_q == ST_STROBE);
  assign in_pseudo = (state_q == ST_PSEUDO1) || (state_q == ST_PSEUDO2);
  assign done      = (state_q == ST_RELEASE) || (state_q == ST_PSEUDO2);
endmodule

// File: rtl/io_onchip_bank.sv
module io_onchip_bank
  import io_cyc_pkg::*;
#(
  parameter int               BW      = BYTE_W,
  parameter int               NUM_RW  = 3,
  parameter logic [NUM_RW*BW-1:0] RW_MAP = {8'h19, 8'h18, 8'h17},
  parameter logic [BW-1:0]    VER_ADR = 8'hFF,
  parameter logic [BW-1:0]    VER_VAL = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] reg_addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata
);
  logic [BW-1:0] rw_q [NUM_RW];

  for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
    logic hit;
    assign hit = (reg_addr == RW_MAP[i*BW +: BW]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rw_q[i] <= '0;
      else if (wr_en && hit) rw_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (reg_addr == VER_ADR) rdata = VER_VAL;
    for (int j = 0; j < NUM_RW; j++) begin
      if (reg_addr == RW_MAP[j*BW +: BW]) rdata = rw_q[j];
    end
  end
endmodule

// File: rtl/io_cycle_gen.sv
module io_cycle_gen
  import io_cyc_pkg::*;
#(
  parameter logic [7:0] VERSION_ID = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op_class,
  input  logic [7:0]  imm_k,
  input  logic [7:0]  imm_l,
  input  logic [7:0]  imm_m,
  input  logic [7:0]  imm_n,
  input  logic [7:0]  acc,
  input  logic [31:0] bc,
  input  logic        wr,
  input  logic [7:0]  wdata,
  output logic [31:0] addr,
  output logic        rd_n,
  output logic        wr_n,
  output logic        done,
  output logic [7:0]  rdata
);
  logic [ADDR_W-1:0] addr_next, addr_q;
  logic [BYTE_W-1:0] wdata_q, bank_rdata;
  logic              wr_q, onchip, load, busy, strobe_en, in_pseudo;

  io_addr_form u_form (
    .op_class (op_class),
    .imm_k    (imm_k),
    .imm_l    (imm_l),
    .imm_m    (imm_m),
    .imm_n    (imm_n),
    .acc      (acc),
    .bc       (bc),
    .addr_next(addr_next),
    .onchip   (onchip)
  );

  io_cycle_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .onchip   (onchip),
    .load     (load),
    .busy     (busy),
    .strobe_en(strobe_en),
    .in_pseudo(in_pseudo),
    .done     (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= addr_next;
      wr_q    <= wr;
      wdata_q <= wdata;
    end
  end

  io_onchip_bank #(.VER_VAL(VERSION_ID)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (done && in_pseudo && wr_q),
    .reg_addr(addr_q[BYTE_W-1:0]),
    .wdata   (wdata_q),
    .rdata   (bank_rdata)
  );

  assign addr  = addr_q;
  assign rd_n  = !(strobe_en && !wr_q);
  assign wr_n  = !(strobe_en && wr_q);
  assign rdata = (done && in_pseudo && !wr_q) ? bank_rdata : '0;
endmodule

// File: rtl/io_cycle_gen_chk.sv
module io_cycle_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  op_class,
  input logic        busy,
  input logic [31:0] addr,
  input logic        rd_n,
  input logic        wr_n,
  input logic        done
);
  // R4: never both strobes at once
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R4: external schedule setup / strobe / release+done
  a_r4_ext_sched: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_class != 3'd6) |=>
      (rd_n && wr_n && !done) ##1 (!(rd_n && wr_n) && !done) ##1 (rd_n && wr_n && done));

  // R5, R6: on-chip pseudo-cycle is two quiet cycles, upper address zero
  a_r6_pseudo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_class == 3'd6) |=>
      (rd_n && wr_n && !done && addr[31:8] == 24'h0) ##1 (rd_n && wr_n && done));

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: address held from strobe through done
  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |=> $stable(addr));

  // R10: a start seen while busy does not extend the operation past done
  a_r10_no_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);
endmodule

bind io_cycle_gen io_cycle_gen_chk u_chk (.*);

// File: tb/io_cycle_gen_test.sv
`timescale 1ns/1ps
module io_cycle_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op_class;
  logic [7:0]  imm_k, imm_l, imm_m, imm_n, acc, wdata;
  logic [31:0] bc;
  logic        wr;
  logic [31:0] addr;
  logic        rd_n, wr_n, done;
  logic [7:0]  rdata;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  io_cycle_gen uut (.*);

  // vector: op(3) klmn(32) acc(8) bc(32) wr(1) exp_addr(32)
  localparam int VW = 108;
  localparam int NV = 8;
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 32'h11223344, 8'hA5, 32'hDEADBEEF, 1'b0, 32'h0000A544},  // R1
    {3'd0, 32'hAABBCCFF, 8'h00, 32'h01020304, 1'b1, 32'h000000FF},  // R1
    {3'd1, 32'h55667788, 8'h3C, 32'hDEADBEEF, 1'b0, 32'hDEADBEEF},  // R2
    {3'd2, 32'h55667788, 8'h3C, 32'h80000001, 1'b1, 32'h80000001},  // R2
    {3'd3, 32'h11223344, 8'h77, 32'hFFFFFFFF, 1'b0, 32'h00003344},  // R3
    {3'd4, 32'h11223344, 8'h77, 32'hFFFFFFFF, 1'b1, 32'h00223344},  // R3
    {3'd5, 32'hFFEEDDCC, 8'h77, 32'h00000000, 1'b0, 32'hFFEEDDCC},  // R3
    {3'd7, 32'h99999999, 8'h12, 32'h12345678, 1'b1, 32'h12345678}   // R2
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] klmn,
                       input logic [7:0] a, input logic [31:0] b,
                       input logic w, input logic [7:0] d);
    op_class = op;
    {imm_k, imm_l, imm_m, imm_n} = klmn;
    acc = a; bc = b; wr = w; wdata = d;
  endtask

  // external op: start on this negedge, check cycles 1..4
  task automatic run_ext(input logic [2:0] op, input logic [31:0] klmn,
                         input logic [7:0] a, input logic [31:0] b,
                         input logic w, input logic [31:0] exp);
    drive(op, klmn, a, b, w, 8'h00);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(addr == exp && rd_n && wr_n && !done, "R1/R2/R3 address in cycle 1", addr, exp);
    @(negedge clk);
    chk(rd_n == w && wr_n == !w && !done, "R4 strobe in cycle 2",
        {30'd0, rd_n, wr_n}, {30'd0, w, !w});
    @(negedge clk);
    chk(done && rd_n && wr_n && addr == exp, "R4 done in cycle 3",
        {31'd0, done}, 32'd1);
    @(negedge clk);
    chk(!done && rd_n && wr_n, "R4 single transaction", {31'd0, done}, 32'd0);
  endtask

  task automatic run_on(input logic [7:0] n, input logic w, input logic [7:0] d,
                        input logic [7:0] exp_rd, input string req);
    drive(3'd6, {24'hFFFFFF, n}, 8'hEE, 32'hFFFFFFFF, w, d);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(addr == {24'h0, n} && rd_n && wr_n && !done, "R5/R6 pseudo cycle 1",
        addr, {24'h0, n});
    @(negedge clk);
    chk(done && rd_n && wr_n, "R5/R6 pseudo cycle 2 done", {29'd0, done, rd_n, wr_n}, 32'd7);
    if (!w) chk(rdata == exp_rd, req, {24'h0, rdata}, {24'h0, exp_rd});
    @(negedge clk);
    chk(!done, "R5 done one cycle", {31'd0, done}, 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    drive(3'd0, 32'h0, 8'h0, 32'h0, 1'b0, 8'h0);
    repeat (3) @(negedge clk);
    chk(addr == 32'h0 && rd_n && wr_n && !done, "R11 reset state", addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr == 32'h0 && rd_n && wr_n && !done, "R11 after reset", addr, 32'h0);

    for (int i = 0; i < NV; i++) begin
      run_ext(VEC[i][107:105], VEC[i][104:73], VEC[i][72:65], VEC[i][64:33],
              VEC[i][32], VEC[i][31:0]);
    end

    // R11: writable registers start at zero; R7 write/read back
    run_on(8'h17, 1'b0, 8'h00, 8'h00, "R11 reg 17 reset value");
    run_on(8'h17, 1'b1, 8'h5A, 8'h00, "R7 write 17");
    run_on(8'h18, 1'b1, 8'hC3, 8'h00, "R7 write 18");
    run_on(8'h19, 1'b1, 8'h81, 8'h00, "R7 write 19");
    run_on(8'h17, 1'b0, 8'h00, 8'h5A, "R7 read 17");
    run_on(8'h18, 1'b0, 8'h00, 8'hC3, "R7 read 18");
    run_on(8'h19, 1'b0, 8'h00, 8'h81, "R7 read 19");

    // R8 version register
    run_on(8'hFF, 1'b0, 8'h00, 8'h00, "R8 version read");
    run_on(8'hFF, 1'b1, 8'h77, 8'h00, "R8 version write");
    run_on(8'hFF, 1'b0, 8'h00, 8'h00, "R8 version unchanged");

    // R9 unmapped and system-control range
    run_on(8'h05, 1'b1, 8'hAB, 8'h00, "R9 write 05");
    run_on(8'h05, 1'b0, 8'h00, 8'h00, "R9 read 05");
    run_on(8'h10, 1'b1, 8'hAB, 8'h00, "R9 write 10");
    run_on(8'h10, 1'b0, 8'h00, 8'h00, "R9 read 10");
    run_on(8'h20, 1'b0, 8'h00, 8'h00, "R9 read 20");
    run_on(8'h16, 1'b0, 8'h00, 8'h00, "R9 read 16");
    run_on(8'h17, 1'b0, 8'h00, 8'h5A, "R9 neighbour writes left 17 intact");

    // R10: start while busy is ignored
    drive(3'd1, 32'h0, 8'h0, 32'hCAFE0001, 1'b0, 8'h0);
    start = 1'b1;
    @(negedge clk);
    drive(3'd5, 32'h0BADF00D, 8'h0, 32'h0, 1'b1, 8'h0);
    chk(addr == 32'hCAFE0001, "R10 cycle 1 address", addr, 32'hCAFE0001);
    @(negedge clk);
    chk(addr == 32'hCAFE0001 && !rd_n && wr_n, "R10 busy start, strobe kept",
        addr, 32'hCAFE0001);
    @(negedge clk); start = 1'b0;
    chk(done && addr == 32'hCAFE0001, "R10 address held to done", addr, 32'hCAFE0001);
    @(negedge clk);
    chk(!done && rd_n && wr_n, "R10 no queued start after done", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(rd_n && wr_n && !done && addr == 32'hCAFE0001, "R10 ignored start not run",
        addr, 32'hCAFE0001);

    // R10: start during on-chip pseudo-cycle ignored
    drive(3'd6, 32'h00000019, 8'h0, 32'h0, 1'b0, 8'h0);
    start = 1'b1;
    @(negedge clk);
    drive(3'd1, 32'h0, 8'h0, 32'h76543210, 1'b0, 8'h0);
    @(negedge clk); start = 1'b0;
    chk(done && rdata == 8'h81 && addr == 32'h19, "R10 pseudo not disturbed",
        {24'h0, rdata}, 32'h81);
    @(negedge clk);
    @(negedge clk);
    chk(addr == 32'h19 && rd_n && wr_n, "R10 no late external cycle", addr, 32'h19);

    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule